// File: doc/BRIEF.md
# Periodic Interrupt Rate Divider

This block turns a 32.768 kHz tick enable into a periodic interrupt whose period is a power of two, selected by a 4-bit rate code. It sits beside a real-time-clock register file. The rate code field of the control register, the periodic enable bit and a pulse issued when software reads the status register come in as plain inputs. Two things go out: a one-cycle pulse that the status register uses to set its periodic and interrupt-pending flags, and a level interrupt request.

A free-running tick counter starts at zero on reset and counts every tick. An expiry happens on the tick that moves the counter onto a whole multiple of the selected period. Interrupts therefore keep to a fixed grid of absolute tick counts. Writing a new rate or toggling the enable changes the decision on the very next tick, but it never restarts the count. Codes 1 and 2 are folded onto codes 8 and 9. Code 0 turns the interrupt off.

Top module: `periodic_irq_divider`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `pf_set` and `irq` are 0. The tick count restarts at 0, so the first expiry comes when the count reaches one full period.
- R2: The tick count advances by one only in cycles where `tick_en` is 1. An expiry can only happen in such a cycle, so there is at most one `pf_set` pulse per tick. The pulse is one cycle long and appears in the cycle after the clock edge that took the tick.
- R3: For rate codes 3 to 15, the period is 2^(code-1) ticks. Code 3 gives a period of 4 ticks and code 15 gives 16384 ticks.
- R4: Rate code 1 behaves exactly like code 8, with a period of 128 ticks. Rate code 2 behaves exactly like code 9, with a period of 256 ticks.
- R5: With rate code 0, no `pf_set` pulse is produced and `irq` is never set, whatever `pie` and `tick_en` do.
- R6: With `pie` at 0, no `pf_set` pulse is produced and `irq` is not set. The rate and enable are looked at on every tick, so a change takes effect on the next tick.
- R7: An expiry happens on the tick that makes the tick count a whole multiple of the current period. The count is taken modulo 2^15 and is not related to the moment the rate was written.
- R8: `irq` rises in the same cycle as `pf_set`. It stays 1 until a cycle with `flag_clr` high and no expiry, and then reads 0 from the next cycle on.
- R9: When an expiry and `flag_clr` fall in the same cycle, the expiry wins and `irq` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle enable, once per 32.768 kHz tick |
| rate_code | input | 4 | Rate select code, 0 = off |
| pie | input | 1 | Periodic interrupt enable |
| flag_clr | input | 1 | Pulse when software reads the status register |
| pf_set | output | 1 | One-cycle pulse that sets the periodic flag and the pending flag |
| irq | output | 1 | Interrupt request level |

## Verification
The bench builds the block with its default parameters: a 15-bit tick counter and a 4-bit rate code. With these, every rate code can be reached, including the 16384-tick period of code 15, which two full expiries cover inside the cycle budget. Ticks are driven either on every cycle or at random density, which puts both the counter-hold path and the back-to-back tick path under test. A mid-run rate change is made at a count that is not on a boundary, to show that expiries stay on the absolute grid. A status clear is placed exactly on an expiry cycle, to show which of the two wins.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int CODE_W = 4;

    typedef struct packed {
        logic              on;
        logic [CODE_W-1:0] eff;
    } rate_sel_t;

    function automatic rate_sel_t fold_rate(input logic [CODE_W-1:0] code, input logic en);
        rate_sel_t r;
        r.on  = en && (code != '0);
        r.eff = (code == 4'd1) ? 4'd8 :
                (code == 4'd2) ? 4'd9 : code;
        return r;
    endfunction

endpackage

// File: rtl/pirq_tick_counter.sv
module pirq_tick_counter #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_next
);

    assign cnt_next = cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (tick_en)
            cnt <= cnt_next;
    end

    // R2: count holds without a tick
    p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(cnt));

endmodule

// File: rtl/pirq_rate_decode.sv
module pirq_rate_decode
    import pirq_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic [CODE_W-1:0] rate_code,
    input  logic              pie,
    output logic              active,
    output logic [CNT_W-1:0]  mask
);

    rate_sel_t sel;

    always_comb sel = fold_rate(rate_code, pie);

    assign active = sel.on;

    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
        assign mask[i] = (i + 1) < int'(sel.eff);
    end

endmodule

// File: rtl/pirq_event.sv
module pirq_event #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             active,
    input  logic [CNT_W-1:0] mask,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic             flag_clr,
    output logic             expiry,
    output logic             pf_set,
    output logic             irq
);

    assign expiry = tick_en && active && ((cnt_next & mask) == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pf_set <= 1'b0;
            irq    <= 1'b0;
        end else begin
            pf_set <= expiry;
            if (expiry)
                irq <= 1'b1;
            else if (flag_clr)
                irq <= 1'b0;
        end
    end

    // R8: a pulse always comes with the request
    p_pulse_sets_irq_r8: assert property (@(posedge clk) disable iff (rst)
        pf_set |-> irq);

    // R8: request holds until cleared
    p_irq_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (irq && !flag_clr) |=> irq);

    // R8: clear without expiry drops the request
    p_irq_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !expiry) |=> !irq);

    // R9: expiry beats a simultaneous clear
    p_expiry_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && expiry) |=> irq);

endmodule

// File: rtl/periodic_irq_divider.sv
module periodic_irq_divider
    import pirq_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [CODE_W-1:0] rate_code,
    input  logic              pie,
    input  logic              flag_clr,
    output logic              pf_set,
    output logic              irq
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_next;
    logic [CNT_W-1:0] mask;
    logic             active;
    logic             expiry;

    pirq_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .cnt      (cnt),
        .cnt_next (cnt_next)
    );

    pirq_rate_decode #(.CNT_W(CNT_W)) u_dec (
        .rate_code (rate_code),
        .pie       (pie),
        .active    (active),
        .mask      (mask)
    );

    pirq_event #(.CNT_W(CNT_W)) u_evt (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .active   (active),
        .mask     (mask),
        .cnt_next (cnt_next),
        .flag_clr (flag_clr),
        .expiry   (expiry),
        .pf_set   (pf_set),
        .irq      (irq)
    );

    // R2: pulses only follow a tick
    p_pulse_needs_tick_r2: assert property (@(posedge clk) disable iff (rst)
        pf_set |-> $past(tick_en));

    // R5: code zero never pulses
    p_no_pulse_code0_r5: assert property (@(posedge clk) disable iff (rst)
        pf_set |-> ($past(rate_code) != '0));

    // R6: enable low never pulses
    p_no_pulse_pie_off_r6: assert property (@(posedge clk) disable iff (rst)
        pf_set |-> $past(pie));

    // R7: pulses land on absolute period boundaries
    p_aligned_r7: assert property (@(posedge clk) disable iff (rst)
        pf_set |-> ((cnt & $past(mask)) == '0));

endmodule

// File: tb/periodic_irq_divider_bench.sv
`timescale 1ns/1ps
module periodic_irq_divider_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic [3:0] rate_code = 4'd0;
    logic       pie = 1'b0;
    logic       flag_clr = 1'b0;
    logic       pf_set;
    logic       irq;

    int     n_chk = 0;
    int     n_bad = 0;
    bit     done = 1'b0;
    int     m_cnt = 0;
    bit     m_irq = 1'b0;
    bit     m_pf = 1'b0;
    string  tag = "R1";

    always #2 clk = ~clk;

    periodic_irq_divider u_periodic_irq_divider (
        .clk(clk), .rst(rst), .tick_en(tick_en), .rate_code(rate_code),
        .pie(pie), .flag_clr(flag_clr), .pf_set(pf_set), .irq(irq)
    );

    function automatic int period_of(input int code);
        int e = (code == 1) ? 8 : (code == 2) ? 9 : code;
        return 1 << (e - 1);
    endfunction

    function automatic bit will_expire(input bit t, input int code, input bit en, input int cnt);
        if (!t || !en || code == 0) return 1'b0;
        return (((cnt + 1) % 32768) % period_of(code)) == 0;
    endfunction

    task automatic check(input string req, input bit a_pf, input bit a_irq);
        n_chk++;
        if (pf_set !== a_pf || irq !== a_irq) begin
            n_bad++;
            $display("FAIL %s pf_set=%0b irq=%0b expected pf_set=%0b irq=%0b",
                     req, pf_set, irq, a_pf, a_irq);
        end
    endtask

    task automatic step(input bit t, input int code, input bit en, input bit clr);
        bit e;
        tick_en   = t;
        rate_code = code[3:0];
        pie       = en;
        flag_clr  = clr;
        e = will_expire(t, code, en, m_cnt);
        @(posedge clk);
        if (t) m_cnt = (m_cnt + 1) % 32768;
        m_pf = e;
        if (e) m_irq = 1'b1;
        else if (clr) m_irq = 1'b0;
        @(negedge clk);
        check(tag, m_pf, m_irq);
    endtask

    task automatic run(input int n, input int code, input bit en, input int dens);
        for (int i = 0; i < n; i++)
            step(($urandom % 100) < dens, code, en, 1'b0);
    endtask

    initial begin
        int pulses;
        void'($urandom(32'd4711));
        // R1: reset state
        repeat (3) begin
            @(posedge clk);
            @(negedge clk);
            check("R1", 1'b0, 1'b0);
        end
        rst = 1'b0;
        tag = "R1";
        step(1'b1, 3, 1'b1, 1'b0);

        // R3: code 3 every tick, count pulses over 40 ticks
        tag = "R3";
        pulses = 0;
        for (int i = 0; i < 40; i++) begin
            step(1'b1, 3, 1'b1, 1'b0);
            pulses += pf_set;
        end
        n_chk++;
        if (pulses != 10) begin
            n_bad++;
            $display("FAIL R3 pulses=%0d expected=%0d", pulses, 10);
        end
        run(33000, 15, 1'b1, 100);
        run(3000, 6, 1'b1, 60);

        // R2: sparse ticks
        tag = "R2";
        step(1'b0, 3, 1'b1, 1'b1);
        run(2000, 4, 1'b1, 30);

        // R4: aliased codes
        tag = "R4";
        step(1'b0, 1, 1'b1, 1'b1);
        run(700, 1, 1'b1, 100);
        run(700, 2, 1'b1, 100);
        run(600, 8, 1'b1, 100);

        // R5: code zero
        tag = "R5";
        step(1'b0, 0, 1'b1, 1'b1);
        run(600, 0, 1'b1, 100);

        // R6: enable off, then back on
        tag = "R6";
        step(1'b0, 3, 1'b0, 1'b1);
        run(600, 3, 1'b0, 100);
        run(100, 3, 1'b1, 100);

        // R7: change rate off a boundary
        tag = "R7";
        run(5, 3, 1'b1, 100);
        step(1'b1, 3, 1'b1, 1'b0);
        run(400, 7, 1'b1, 100);

        // R8: clears between expiries
        tag = "R8";
        for (int i = 0; i < 1500; i++)
            step(($urandom % 2) == 0, 5, 1'b1, ($urandom % 16) == 0);

        // R9: clear exactly on expiry
        tag = "R9";
        for (int k = 0; k < 5; k++) begin
            while (!will_expire(1'b1, 4, 1'b1, m_cnt))
                step(1'b1, 4, 1'b1, 1'b1);
            step(1'b1, 4, 1'b1, 1'b1);
        end

        // R7: random mix
        tag = "R7";
        for (int i = 0; i < 20000; i++)
            step(($urandom % 4) != 0, $urandom % 16, ($urandom % 8) != 0,
                 ($urandom % 32) == 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule